// File: doc/BRIEF.md
# Sixteen-Bit Flag-Keeping ALU

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle it takes a 5-bit operation code, two 16-bit operands and its own stored carry. It computes a result through combinational logic. Alongside the result it drives a write strobe that tells the surrounding datapath whether the result should go back into the destination register.

The block keeps four flags in registers: carry, zero, lesser and greater. They change only on a clock edge on which the enable is high. The carry flag holds the carry-out or borrow of arithmetic and the bit shifted out by shifts and rotates. The same stored carry feeds back into the carry-using adds and subtracts and into the rotates. Compare writes no result. It only sets the three comparison flags.

Top module: `flag_alu`

## Requirements
- R1: While reset is low, and on the first edge after it is released, the carry, zero, lesser and greater flags all read 0.
- R2: Codes 0x01 MOV (result = B), 0x02 AND, 0x03 OR, 0x04 NOT (result = ~A) and 0x05 XOR each produce their result with the write strobe high, and they leave the carry flag unchanged.
- R3: Code 0x06 gives A+B and 0x13 gives A+B+carry, with the carry-out written to carry. Code 0x07 gives A-B and 0x14 gives A-B-carry, with the borrow written to carry (1 when the true difference is negative). All results are taken modulo 2^16.
- R4: Code 0x08 gives A+1 with carry = carry-out. Code 0x09 gives A-1 with carry = 1 only when A is 0. Code 0x15 gives the two's complement of A with carry = 1 when A is nonzero.
- R5: Code 0x0A shifts A left one bit with bit 0 = 0 and carry = old bit 15. Code 0x0B shifts A right one bit with bit 15 = 0 and carry = old bit 0.
- R6: Code 0x0C rotates left through carry: bit 0 = old carry and carry = old bit 15. Code 0x0D rotates right through carry: bit 15 = old carry and carry = old bit 0.
- R7: Code 0x16 shifts left and keeps bit 15 (result = {A[15], A[13:0], 0}), with carry = old bit 15. Code 0x17 shifts right and copies bit 15 into bits 15 and 14, with carry = old bit 0.
- R8: Code 0x0E holds the write strobe low and sets zero = (A == B), lesser = (A < B unsigned) and greater = (A > B unsigned). Exactly one of these three flags is set, and carry is unchanged.
- R9: Every operation that produces a result sets the zero flag to (result == 0). Lesser and greater change only on compare.
- R10: While the enable is low, the write strobe is low and all four flags hold their values.
- R11: Code 0x00 and every code not listed above hold the write strobe low and leave all four flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| en | input | 1 | Execute this cycle's operation |
| op | input | 5 | Operation code |
| opa | input | 16 | First operand (destination register value) |
| opb | input | 16 | Second operand |
| res | output | 16 | Combinational result |
| res_we | output | 1 | Result should be written back |
| cf | output | 1 | Carry / borrow flag |
| zf | output | 1 | Zero flag |
| lf | output | 1 | Lesser flag |
| gf | output | 1 | Greater flag |

## Verification
The assertions check the following on every cycle: the flags hold while disabled, compare never raises the write strobe and leaves exactly one comparison flag set, logic operations leave carry alone, only compare moves lesser or greater, and the zero flag follows the previous result. The shift and rotate carry paths are also covered by assertions. The arithmetic values themselves can only be shown by the bench's scenarios. It compares every code against an independent model over random operands, and over the corner values 0x0000, 0xFFFF and 0x8000 with carry preset both ways. This makes visible the carry chains into ADC, SBB and the rotates, the borrow edge cases of DEC and NEG, and the silence of unused codes.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [4:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic         cf,
  output logic         zf,
  output logic         lf,
  output logic         gf
);

  localparam logic [4:0] OP_MOV = 5'h01, OP_AND = 5'h02, OP_OR  = 5'h03,
                         OP_NOT = 5'h04, OP_XOR = 5'h05, OP_ADD = 5'h06,
                         OP_SUB = 5'h07, OP_INC = 5'h08, OP_DEC = 5'h09,
                         OP_SHL = 5'h0A, OP_SHR = 5'h0B, OP_ROL = 5'h0C,
                         OP_ROR = 5'h0D, OP_CMP = 5'h0E, OP_ADC = 5'h13,
                         OP_SBB = 5'h14, OP_NEG = 5'h15, OP_ASL = 5'h16,
                         OP_ASR = 5'h17;

  logic [W:0]   ea, eb, ec;
  logic [W-1:0] r;
  logic         c_n, has_res, is_cmp;

  assign ea     = {1'b0, opa};
  assign eb     = {1'b0, opb};
  assign ec     = (W+1)'(cf);
  assign is_cmp = (op == OP_CMP);
  assign res    = r;
  assign res_we = en && has_res;

  always_comb begin
    r       = '0;
    c_n     = cf;
    has_res = 1'b1;
    case (op)
      OP_MOV: r = opb;
      OP_AND: r = opa & opb;
      OP_OR:  r = opa | opb;
      OP_NOT: r = ~opa;
      OP_XOR: r = opa ^ opb;
      OP_ADD: {c_n, r} = ea + eb;
      OP_ADC: {c_n, r} = ea + eb + ec;
      OP_SUB: {c_n, r} = ea - eb;
      OP_SBB: {c_n, r} = ea - eb - ec;
      OP_INC: {c_n, r} = ea + (W+1)'(1);
      OP_DEC: {c_n, r} = ea - (W+1)'(1);
      OP_NEG: {c_n, r} = (W+1)'(0) - ea;
      OP_SHL: begin r = {opa[W-2:0], 1'b0};          c_n = opa[W-1]; end
      OP_SHR: begin r = {1'b0, opa[W-1:1]};          c_n = opa[0];   end
      OP_ROL: begin r = {opa[W-2:0], cf};            c_n = opa[W-1]; end
      OP_ROR: begin r = {cf, opa[W-1:1]};            c_n = opa[0];   end
      OP_ASL: begin r = {opa[W-1], opa[W-3:0], 1'b0}; c_n = opa[W-1]; end
      OP_ASR: begin r = {opa[W-1], opa[W-1:1]};      c_n = opa[0];   end
      default: has_res = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cf <= 1'b0;
      zf <= 1'b0;
      lf <= 1'b0;
      gf <= 1'b0;
    end else if (en) begin
      if (is_cmp) begin
        zf <= (opa == opb);
        lf <= (opa < opb);
        gf <= (opa > opb);
      end else if (has_res) begin
        zf <= (r == '0);
        cf <= c_n;
      end
    end
  end

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({cf, zf, lf, gf})); // R10
  AST_NO_WE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !res_we); // R10
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_CMP |-> !res_we); // R8
  AST_CMP_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_CMP |=> $countones({zf, lf, gf}) == 1); // R8
  AST_CMP_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_CMP |=> $stable(cf)); // R8
  AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    en && op >= OP_MOV && op <= OP_XOR |=> $stable(cf)); // R2
  AST_LG_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    op != OP_CMP |=> $stable({lf, gf})); // R9
  AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> zf == ($past(res) == '0)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_we && op != OP_CMP |=> $stable({cf, zf, lf, gf})); // R11
  AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_SHL |=> cf == $past(opa[W-1])); // R5
  AST_SHR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == OP_SHR |=> cf == $past(opa[0])); // R5
  AST_ROR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_ROR |-> res[W-1] == cf); // R6
  AST_ROL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_ROL |-> res[0] == cf); // R6

endmodule

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;
  localparam int W = 16;
  localparam int CLK_NS = 20;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [4:0] op = '0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] res;
  logic res_we, cf, zf, lf, gf;

  int total = 0, fails = 0;
  bit done = 0;
  logic m_c = 0, m_z = 0, m_l = 0, m_g = 0;

  always #(CLK_NS/2) clk = ~clk;

  flag_alu #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opa(opa), .opb(opb),
    .res(res), .res_we(res_we), .cf(cf), .zf(zf), .lf(lf), .gf(gf)
  );

  function automatic string tag(input logic [4:0] o);
    case (o)
      5'h01, 5'h02, 5'h03, 5'h04, 5'h05: return "R2";
      5'h06, 5'h07, 5'h13, 5'h14:        return "R3";
      5'h08, 5'h09, 5'h15:               return "R4";
      5'h0A, 5'h0B:                      return "R5";
      5'h0C, 5'h0D:                      return "R6";
      5'h16, 5'h17:                      return "R7";
      5'h0E:                             return "R8";
      default:                           return "R11";
    endcase
  endfunction

  // returns {has_result, carry_next, result}
  function automatic logic [W+1:0] model(input logic [4:0] o, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic c);
    int unsigned ua, ub, uc;
    logic [W-1:0] r;
    logic cn, h;
    ua = a; ub = b; uc = c;
    r = '0; cn = c; h = 1'b1;
    case (o)
      5'h01: r = b;
      5'h02: r = a & b;
      5'h03: r = a | b;
      5'h04: r = ~a;
      5'h05: r = a ^ b;
      5'h06: begin r = W'(ua + ub);      cn = (ua + ub) > 65535; end
      5'h13: begin r = W'(ua + ub + uc); cn = (ua + ub + uc) > 65535; end
      5'h07: begin r = W'(ua - ub);      cn = ua < ub; end
      5'h14: begin r = W'(ua - ub - uc); cn = ua < ub + uc; end
      5'h08: begin r = W'(ua + 1);       cn = (ua == 65535); end
      5'h09: begin r = W'(ua - 1);       cn = (ua == 0); end
      5'h15: begin r = W'(65536 - ua);   cn = (ua != 0); end
      5'h0A: begin r = W'(ua * 2);       cn = a[15]; end
      5'h0B: begin r = W'(ua / 2);       cn = a[0]; end
      5'h0C: begin r = W'(ua * 2 + uc);  cn = a[15]; end
      5'h0D: begin r = W'(ua / 2 + uc * 32768); cn = a[0]; end
      5'h16: begin r = W'((ua * 2) % 32768 + (a[15] ? 32768 : 0)); cn = a[15]; end
      5'h17: begin r = W'(ua / 2 + (a[15] ? 32768 : 0)); cn = a[0]; end
      default: h = 1'b0;
    endcase
    return {h, cn, r};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] o, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic e);
    logic [W+1:0] m;
    string t;
    @(negedge clk);
    op = o; opa = a; opb = b; en = e;
    m = model(o, a, b, m_c);
    t = e ? tag(o) : "R10";
    #2;
    chk(res_we == (e && m[W+1]), t, "write strobe", W'(res_we), W'(e && m[W+1]));
    if (e && m[W+1]) chk(res == m[W-1:0], t, "result", res, m[W-1:0]);
    @(posedge clk);
    if (e) begin
      if (o == 5'h0E) begin
        m_z = (a == b); m_l = (a < b); m_g = (a > b);
      end else if (m[W+1]) begin
        m_z = (m[W-1:0] == '0); m_c = m[W];
      end
    end
    #2;
    chk({cf, zf, lf, gf} == {m_c, m_z, m_l, m_g}, (e && m[W+1]) ? "R9" : t,
        "flags cf,zf,lf,gf", W'({cf, zf, lf, gf}), W'({m_c, m_z, m_l, m_g}));
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corner [4];
    corner[0] = 16'h0000; corner[1] = 16'hFFFF; corner[2] = 16'h8000; corner[3] = 16'h1234;
    void'($urandom(32'd7411));
    repeat (3) @(posedge clk);
    #2;
    chk({cf, zf, lf, gf} == 4'b0, "R1", "flags in reset", W'({cf, zf, lf, gf}), '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk({cf, zf, lf, gf} == 4'b0, "R1", "flags after reset", W'({cf, zf, lf, gf}), '0);

    // R10: disabled operations do nothing, after flags set to a known pattern
    step(5'h0A, 16'h8000, 16'h0000, 1'b1);
    step(5'h0E, 16'h0001, 16'h0002, 1'b1);
    step(5'h06, 16'hFFFF, 16'h0001, 1'b0);
    step(5'h0E, 16'h0005, 16'h0005, 1'b0);
    step(5'h0B, 16'h0000, 16'h0000, 1'b0);

    // directed corners for every code, carry preset both ways
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int c = 0; c < 2; c++) begin
            step(5'h0A, c ? 16'h8000 : 16'h0000, 16'h0000, 1'b1);
            step(5'(o), corner[i], corner[j], 1'b1);
          end

    // random mix
    for (int k = 0; k < 4000; k++)
      step(5'($urandom_range(0, 31)), 16'($urandom), 16'($urandom),
           ($urandom_range(0, 9) != 0));

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule